// File: doc/BRIEF.md
# Transmit Status Flag Tracker

This block keeps the per-frame status word of an Ethernet transmitter that runs in half or full duplex. The transmit engine sends it single-cycle strobes for frame start, frame end, collisions, late collisions, carrier loss and SQE pulses. It also drives a level that marks the inter-frame gap window and a bit that says whether the frame is multicast. From these the block keeps six sticky flags: SQE-test failure, sixteen-collision abort, last-frame multicast, multiple collision, single collision and transmit success. It also owns the transmit-enable bit. Host logic sets that bit with a write strobe, and the block forces it low when a frame reaches sixteen collisions.

A frame is judged when its gap window closes. The judgement falls on the first cycle after the frame-end strobe in which the gap window is low. Pulses seen while the window was open count as a passing SQE test. In half duplex, a frame fails on any of four conditions: sixteen collisions, a missed SQE pulse when the SQE stop option is on, carrier loss when carrier monitoring is on, or a late collision. In full duplex every frame is judged successful. A new frame start is accepted only while the block is idle, or in the very cycle the previous frame is judged.

Top module: `tx_status_tracker`

## Requirements
- R1: When `rst_n` is low, or `sw_rst` is high, at a rising clock edge, every flag output, `txen` and `txen_clr_req` read 0 after that edge.
- R2: A `txen_wr` strobe makes `txen` read 1 after the next edge. At that same edge it clears `flag_sqet`, `flag_col16` and `flag_tx_ok`. It leaves the multicast, single-collision and multiple-collision flags unchanged.
- R3: The first collision pulse of a frame sets `flag_single_col`. Any later collision pulse in the same frame sets `flag_multi_col`. `flag_multi_col` is never 1 while `flag_single_col` is 0.
- R4: The per-frame collision count restarts at each accepted frame start and saturates at 16. The 16th pulse sets `flag_col16` and drives `txen` to 0 at the same edge, and `txen_clr_req` is high for exactly that one following cycle. Further collision pulses change neither `flag_col16`, `txen` nor `txen_clr_req`.
- R5: At each accepted frame start, `flag_last_mcast` is loaded with `is_mcast`.
- R6: At an accepted frame start, both collision flags are cleared only if `flag_tx_ok` is 1 at that moment. If it is 0, they keep their values.
- R7: A frame is judged in the first cycle after `frame_end` in which `ipg_win` is low. After that edge `flag_tx_ok` is 1 if the frame had no fatal error. An accepted frame start clears `flag_tx_ok`.
- R8: With `cfg_full_dup`=0, a frame is fatal on any of these: 16 collisions, SQE failure with `cfg_stop_sqe`=1, a carrier-loss pulse with `cfg_mon_crs`=1, or a late-collision pulse. With `cfg_full_dup`=1 no frame is fatal.
- R9: At judgement, `flag_sqet` is set when `cfg_full_dup`=0, `cfg_stop_sqe`=1 and no `sqe_pulse` arrived while `ipg_win` was high after `frame_end`. SQE pulses outside that window do not count. Only `txen_wr` or a reset clears the flag.
- R10: When a flag's set event and clear event fall in the same cycle, the set wins. This covers success judgement against frame start, the 16th collision against `txen_wr`, and SQE failure against `txen_wr`. For `txen` itself, the forced low from the 16th collision wins over `txen_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, active high |
| frame_start | input | 1 | Strobe: a frame begins |
| frame_end | input | 1 | Strobe: frame transmission finished |
| coll_pulse | input | 1 | Strobe: one collision |
| late_coll | input | 1 | Strobe: late collision |
| carrier_lost | input | 1 | Strobe: carrier dropped during transmit |
| sqe_pulse | input | 1 | Strobe: SQE heartbeat seen |
| ipg_win | input | 1 | High while the gap window after a frame is open |
| is_mcast | input | 1 | Frame is multicast, sampled at frame start |
| cfg_full_dup | input | 1 | 1 = full duplex |
| cfg_stop_sqe | input | 1 | Treat missing SQE pulse as fatal |
| cfg_mon_crs | input | 1 | Treat carrier loss as fatal |
| txen_wr | input | 1 | Write strobe setting transmit enable |
| txen | output | 1 | Transmit enable |
| txen_clr_req | output | 1 | One-cycle pulse when transmit enable is forced low |
| flag_sqet | output | 1 | SQE test failed |
| flag_col16 | output | 1 | Sixteen collisions reached |
| flag_last_mcast | output | 1 | Last frame was multicast |
| flag_multi_col | output | 1 | More than one collision |
| flag_single_col | output | 1 | At least one collision |
| flag_tx_ok | output | 1 | Last frame transmitted without fatal error |

## Verification
Two pairs of functions can meet in one cycle. The judgement of one frame can coincide with the start of the next, so the success set races its own clear. The 16th collision can coincide with a host write to transmit enable, so the force-low races the set. The bench provokes each by driving both strobes for the same single edge. It judges the result against R10: success and the sixteen-collision flag must read 1, and `txen` must read 0. A third case drives a failed SQE judgement together with `txen_wr` and expects `flag_sqet` to survive.

// File: rtl/tx_stat_pkg.sv
// Shared types and defaults for the transmit status tracker.
package tx_stat_pkg;
    // Frame phase as seen by the status logic.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_GAP  = 2'd2
    } tx_phase_e;

    // Default collision count that aborts a frame.
    localparam int COLL_LIMIT_DEF = 16;
endpackage

// File: rtl/tx_coll_counter.sv
// Per-frame collision counter.
// Restarts at each accepted frame start and saturates at LIMIT. It turns
// collision pulses into first / further / limit events for the flag bank.
// Assumes collision pulses are single-cycle strobes.
module tx_coll_counter #(
    parameter int LIMIT = tx_stat_pkg::COLL_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic coll,
    output logic first_ev,
    output logic more_ev,
    output logic limit_ev,
    output logic limit_hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q, base, cnt_d;

    // Count basis for this cycle: zero when a new frame starts.
    always_comb begin
        base  = start_acc ? '0 : cnt_q;
        cnt_d = (coll && base < LIM_V) ? base + 1'b1 : base;
    end

    assign first_ev  = coll && (base == '0);
    assign more_ev   = coll && (base != '0);
    assign limit_ev  = coll && (base == LIM_M1);
    assign limit_hit = (cnt_q == LIM_V);

    // Hold the running collision count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);
endmodule

// File: rtl/tx_frame_monitor.sv
// Frame phase tracker and judge.
// Follows idle -> send -> gap and latches the error events of the current
// frame. In the first gap cycle with the window closed it emits a one-cycle
// verdict. A new start is accepted only when idle or in the verdict cycle.
module tx_frame_monitor
    import tx_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_end,
    input  logic late_coll,
    input  logic carrier_lost,
    input  logic sqe_pulse,
    input  logic ipg_win,
    input  logic limit_hit,
    input  logic cfg_full_dup,
    input  logic cfg_stop_sqe,
    input  logic cfg_mon_crs,
    output logic start_acc,
    output logic verdict,
    output logic frame_ok,
    output logic sqe_fail
);
    tx_phase_e phase_q, phase_d;
    logic late_q, carr_q, sqe_q;
    logic half;

    assign half      = !cfg_full_dup;
    assign verdict   = (phase_q == PH_GAP) && !ipg_win;
    assign start_acc = frame_start && ((phase_q == PH_IDLE) || verdict);
    assign sqe_fail  = half && cfg_stop_sqe && !sqe_q;
    assign frame_ok  = !(half && (limit_hit || sqe_fail ||
                                  (cfg_mon_crs && carr_q) || late_q));

    // Next frame phase.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (start_acc) phase_d = PH_SEND;
            PH_SEND: if (frame_end) phase_d = PH_GAP;
            PH_GAP:  if (verdict)   phase_d = start_acc ? PH_SEND : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Per-frame error latches, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            late_q <= 1'b0;
            carr_q <= 1'b0;
            sqe_q  <= 1'b0;
        end else begin
            if (phase_q == PH_SEND && late_coll)    late_q <= 1'b1;
            if (phase_q == PH_SEND && carrier_lost) carr_q <= 1'b1;
            if (phase_q == PH_GAP && ipg_win && sqe_pulse) sqe_q <= 1'b1;
        end
    end

    // R7
    verdict_leaves_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict |=> phase_q != PH_GAP);
    // R7
    start_enters_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> phase_q == PH_SEND);
endmodule

// File: rtl/tx_flag_bank.sv
// Sticky status flags and the transmit-enable bit.
// Each flag has its own set and clear event, and a set wins over a clear in
// the same cycle. The sixteenth collision forces transmit enable low and
// overrides a host write in the same cycle.
module tx_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic is_mcast,
    input  logic first_ev,
    input  logic more_ev,
    input  logic limit_ev,
    input  logic verdict,
    input  logic frame_ok,
    input  logic sqe_fail,
    input  logic txen_wr,
    output logic txen,
    output logic txen_clr_req,
    output logic flag_sqet,
    output logic flag_col16,
    output logic flag_last_mcast,
    output logic flag_multi_col,
    output logic flag_single_col,
    output logic flag_tx_ok
);
    logic txen_q, clr_q, sqet_q, col16_q, mc_q, multi_q, single_q, ok_q;
    logic coll_clr;

    assign coll_clr = start_acc && ok_q;

    // Update all flags and transmit enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txen_q   <= 1'b0;
            clr_q    <= 1'b0;
            sqet_q   <= 1'b0;
            col16_q  <= 1'b0;
            mc_q     <= 1'b0;
            multi_q  <= 1'b0;
            single_q <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            clr_q <= limit_ev;
            if (limit_ev)     txen_q <= 1'b0;
            else if (txen_wr) txen_q <= 1'b1;

            if (verdict && sqe_fail) sqet_q <= 1'b1;
            else if (txen_wr)        sqet_q <= 1'b0;

            if (limit_ev)     col16_q <= 1'b1;
            else if (txen_wr) col16_q <= 1'b0;

            if (start_acc) mc_q <= is_mcast;

            if (first_ev)      single_q <= 1'b1;
            else if (coll_clr) single_q <= 1'b0;

            if (more_ev)       multi_q <= 1'b1;
            else if (coll_clr) multi_q <= 1'b0;

            if (verdict && frame_ok)       ok_q <= 1'b1;
            else if (start_acc || txen_wr) ok_q <= 1'b0;
        end
    end

    assign txen            = txen_q;
    assign txen_clr_req    = clr_q;
    assign flag_sqet       = sqet_q;
    assign flag_col16      = col16_q;
    assign flag_last_mcast = mc_q;
    assign flag_multi_col  = multi_q;
    assign flag_single_col = single_q;
    assign flag_tx_ok      = ok_q;

    // R4
    abort_drops_txen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col16_q) |-> (!txen_q && clr_q));
    // R4
    clr_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q);
    // R3
    multi_needs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_q |-> single_q);
    // R9
    sqet_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sqet_q) && !$past(txen_wr)) |-> sqet_q);
endmodule

// File: rtl/tx_status_tracker.sv
// Top of the transmit status tracker.
// Merges hardware and software reset and wires the frame judge, the
// collision counter and the flag bank together. Assumes every event input
// is a single-cycle strobe in the clock domain of clk.
module tx_status_tracker #(
    parameter int COLL_LIMIT = tx_stat_pkg::COLL_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic frame_start,
    input  logic frame_end,
    input  logic coll_pulse,
    input  logic late_coll,
    input  logic carrier_lost,
    input  logic sqe_pulse,
    input  logic ipg_win,
    input  logic is_mcast,
    input  logic cfg_full_dup,
    input  logic cfg_stop_sqe,
    input  logic cfg_mon_crs,
    input  logic txen_wr,
    output logic txen,
    output logic txen_clr_req,
    output logic flag_sqet,
    output logic flag_col16,
    output logic flag_last_mcast,
    output logic flag_multi_col,
    output logic flag_single_col,
    output logic flag_tx_ok
);
    logic rst_eff_n;
    logic start_acc, verdict, frame_ok, sqe_fail;
    logic first_ev, more_ev, limit_ev, limit_hit;

    // Either reset source clears the whole block.
    assign rst_eff_n = rst_n && !sw_rst;

    tx_frame_monitor u_judge (
        .clk(clk), .rst_n(rst_eff_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .late_coll(late_coll), .carrier_lost(carrier_lost),
        .sqe_pulse(sqe_pulse), .ipg_win(ipg_win), .limit_hit(limit_hit),
        .cfg_full_dup(cfg_full_dup), .cfg_stop_sqe(cfg_stop_sqe),
        .cfg_mon_crs(cfg_mon_crs),
        .start_acc(start_acc), .verdict(verdict),
        .frame_ok(frame_ok), .sqe_fail(sqe_fail)
    );

    tx_coll_counter #(.LIMIT(COLL_LIMIT)) u_coll (
        .clk(clk), .rst_n(rst_eff_n), .start_acc(start_acc), .coll(coll_pulse),
        .first_ev(first_ev), .more_ev(more_ev),
        .limit_ev(limit_ev), .limit_hit(limit_hit)
    );

    tx_flag_bank u_flags (
        .clk(clk), .rst_n(rst_eff_n), .start_acc(start_acc), .is_mcast(is_mcast),
        .first_ev(first_ev), .more_ev(more_ev), .limit_ev(limit_ev),
        .verdict(verdict), .frame_ok(frame_ok), .sqe_fail(sqe_fail),
        .txen_wr(txen_wr),
        .txen(txen), .txen_clr_req(txen_clr_req), .flag_sqet(flag_sqet),
        .flag_col16(flag_col16), .flag_last_mcast(flag_last_mcast),
        .flag_multi_col(flag_multi_col), .flag_single_col(flag_single_col),
        .flag_tx_ok(flag_tx_ok)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_eff_n |=> !(txen || flag_sqet || flag_col16 || flag_tx_ok ||
                         flag_single_col || flag_multi_col || flag_last_mcast));
endmodule

// File: tb/test_tx_status_tracker.sv
// Directed bench: one task per scenario; inputs change on falling edges.
module test_tx_status_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0, sw_rst = 1'b0;
    logic frame_start = 0, frame_end = 0, coll_pulse = 0, late_coll = 0;
    logic carrier_lost = 0, sqe_pulse = 0, ipg_win = 0, is_mcast = 0;
    logic cfg_full_dup = 0, cfg_stop_sqe = 1, cfg_mon_crs = 1, txen_wr = 0;
    logic txen, txen_clr_req, flag_sqet, flag_col16, flag_last_mcast;
    logic flag_multi_col, flag_single_col, flag_tx_ok;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    tx_status_tracker i_tx_status_tracker (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .frame_start(frame_start), .frame_end(frame_end),
        .coll_pulse(coll_pulse), .late_coll(late_coll),
        .carrier_lost(carrier_lost), .sqe_pulse(sqe_pulse), .ipg_win(ipg_win),
        .is_mcast(is_mcast), .cfg_full_dup(cfg_full_dup),
        .cfg_stop_sqe(cfg_stop_sqe), .cfg_mon_crs(cfg_mon_crs),
        .txen_wr(txen_wr), .txen(txen), .txen_clr_req(txen_clr_req),
        .flag_sqet(flag_sqet), .flag_col16(flag_col16),
        .flag_last_mcast(flag_last_mcast), .flag_multi_col(flag_multi_col),
        .flag_single_col(flag_single_col), .flag_tx_ok(flag_tx_ok)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flags as {sqet, col16, last_mcast, multi, single, tx_ok}.
    function automatic logic [5:0] flags();
        return {flag_sqet, flag_col16, flag_last_mcast,
                flag_multi_col, flag_single_col, flag_tx_ok};
    endfunction

    task automatic begin_frame(logic mc);
        frame_start = 1; is_mcast = mc; tick(); frame_start = 0; is_mcast = 0;
    endtask

    task automatic collide(int n);
        for (int i = 0; i < n; i++) begin
            coll_pulse = 1; tick(); coll_pulse = 0; tick();
        end
    endtask

    task automatic finish_frame(int ncoll, logic late, logic carr, logic sqe);
        collide(ncoll);
        if (late) begin late_coll = 1; tick(); late_coll = 0; end
        if (carr) begin carrier_lost = 1; tick(); carrier_lost = 0; end
        frame_end = 1; tick(); frame_end = 0;
        ipg_win = 1; sqe_pulse = sqe; tick(); sqe_pulse = 0; tick();
        ipg_win = 0; tick();
    endtask

    task automatic wr_txen();
        txen_wr = 1; tick(); txen_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 flags", flags(), 6'b0);
        chk("R1 txen", txen, 0);
        chk("R1 clr_req", txen_clr_req, 0);
        wr_txen();
        chk("R2 txen set", txen, 1);
    endtask

    task automatic t_good_frames();
        begin_frame(1); finish_frame(0, 0, 0, 1);
        chk("R5 R7 clean multicast", flags(), 6'b001001);
        begin_frame(0); finish_frame(1, 0, 0, 1);
        chk("R3 single collision", flags(), 6'b000011);
        begin_frame(0);
        chk("R6 start clears after success", flags(), 6'b000000);
        finish_frame(0, 0, 0, 1);
        chk("R7 success again", flags(), 6'b000001);
    endtask

    task automatic t_sqe();
        begin_frame(0);
        sqe_pulse = 1; tick(); sqe_pulse = 0;   // outside the gap window
        finish_frame(3, 0, 0, 0);
        chk("R9 R8 R3 sqe fail", flags(), 6'b100110);
        begin_frame(0);
        chk("R6 kept after failure", flags(), 6'b100110);
        finish_frame(0, 0, 0, 1);
        chk("R9 sticky over good frame", flags(), 6'b100111);
        wr_txen();
        chk("R2 write clears", flags(), 6'b000110);
        chk("R2 txen", txen, 1);
    endtask

    task automatic t_fatal();
        begin_frame(0); finish_frame(0, 0, 1, 1);
        chk("R8 carrier monitored", flag_tx_ok, 0);
        cfg_mon_crs = 0;
        begin_frame(0); finish_frame(0, 0, 1, 1);
        chk("R8 carrier unmonitored", flag_tx_ok, 1);
        cfg_mon_crs = 1;
        begin_frame(0); finish_frame(0, 1, 0, 1);
        chk("R8 late collision", flag_tx_ok, 0);
        cfg_full_dup = 1;
        begin_frame(0); finish_frame(0, 1, 1, 0);
        chk("R8 full duplex ok", flag_tx_ok, 1);
        chk("R9 full duplex no sqet", flag_sqet, 0);
        cfg_full_dup = 0;
    endtask

    task automatic t_coll16();
        begin_frame(0); collide(15);
        chk("R4 below limit", {flag_col16, txen}, 2'b01);
        coll_pulse = 1; tick(); coll_pulse = 0;
        chk("R4 limit", {flag_col16, txen, txen_clr_req}, 3'b101);
        tick();
        chk("R4 clr pulse ends", txen_clr_req, 0);
        collide(1);
        chk("R4 saturated", {flag_col16, txen, txen_clr_req}, 3'b100);
        finish_frame(0, 0, 0, 1);
        chk("R8 16 collisions fatal", flag_tx_ok, 0);
        wr_txen();
        chk("R2 write clears col16", {flag_col16, txen}, 2'b01);
    endtask

    task automatic t_same_cycle();
        begin_frame(0); collide(15);
        coll_pulse = 1; txen_wr = 1; tick(); coll_pulse = 0; txen_wr = 0;
        chk("R10 col16 vs write", {flag_col16, txen}, 2'b10);
        finish_frame(0, 0, 0, 1);
        wr_txen();
        begin_frame(0);
        frame_end = 1; tick(); frame_end = 0;
        ipg_win = 1; sqe_pulse = 1; tick(); sqe_pulse = 0;
        ipg_win = 0; frame_start = 1; is_mcast = 1; tick();
        frame_start = 0; is_mcast = 0;
        chk("R10 verdict vs start", {flag_tx_ok, flag_last_mcast}, 2'b11);
        finish_frame(0, 0, 0, 1);
        chk("R7 back-to-back frame", flag_tx_ok, 1);
        begin_frame(0);
        frame_end = 1; tick(); frame_end = 0;
        ipg_win = 1; tick(); ipg_win = 0; txen_wr = 1; tick(); txen_wr = 0;
        chk("R10 sqet vs write", {flag_sqet, flag_tx_ok, txen}, 3'b101);
    endtask

    task automatic t_swrst();
        sw_rst = 1; tick(); sw_rst = 0;
        chk("R1 soft reset flags", flags(), 6'b0);
        chk("R1 soft reset txen", txen, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_good_frames();
        t_sqe();
        t_fatal();
        t_coll16();
        t_same_cycle();
        t_swrst();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule